// File: doc/BRIEF.md
# Three-Phase Nonoverlapping Switch-Phase Generator

This block takes one fast master clock and turns it into the three switch-control phases that a switched-capacitor modulator and its control logic need in each modulator cycle. The phases always come in the same order. The precharge phase comes first. The integrate phase comes second. The reference-select phase comes third. A dead time of a programmable number of master-clock cycles lies between any two phases, and no two phases are ever high at the same time.

The first two phases each drive a pair of control lines. The primary line of a pair is high for the whole width of its phase. The secondary line is high only in the inside of that window, held back by an inset at both ends, so the secondary switch opens before the primary one. In phase one the primary line precharges the inverting amplifier and the secondary line admits the reference. In phase two the primary line passes the integrator value to the comparator and the secondary line switches in the sampled input. Phase three drives one line, which selects the reference for the next integration.

Two single-cycle signals come with the phases. The first is derived from the first precharge line and marks the first cycle of each modulator cycle. The second marks the last cycle of phase three, which a conversion sequencer can use. A `run` level starts the phase sequence. The generator stops only at the boundary between modulator cycles, so it never cuts a phase short.

Top module: `nolap_clkgen3`

## Requirements
- R1: While `rst` is sampled high, and on every later edge until a modulator cycle starts, all seven outputs are low.
- R2: When the generator is idle and `run` is sampled high on a rising edge, `pre_amp` first goes high on the next rising edge. Position 0 of the modulator cycle is the first cycle in which `pre_amp` is high.
- R3: `pre_amp` is high at positions 0 to PH1_W-1 of each modulator cycle. A modulator cycle is PH1_W+PH2_W+PH3_W+3*GAP_W cycles long.
- R4: `pre_ref` is high only at offsets INSET to PH1_W-INSET-1 inside phase one, so it is always enclosed by `pre_amp`.
- R5: `int_cmp` is high for PH2_W cycles, starting at position PH1_W+GAP_W.
- R6: `int_in` is high only at offsets INSET to PH2_W-INSET-1 inside phase two, so it is always enclosed by `int_cmp`.
- R7: `ref_sel` is high for PH3_W cycles, starting at position PH1_W+PH2_W+2*GAP_W. GAP_W low cycles follow it before the next modulator cycle starts.
- R8: No two of the phases {`pre_amp`, `int_cmp`, `ref_sel`} are ever high together. Each phase rises only after the phase before it in the order 1, 2, 3, 1 has ended. At least GAP_W cycles with all three phases low lie between the two.
- R9: `cyc_start` is high for exactly one cycle, the first cycle of each phase one, and at no other time.
- R10: `cyc_done` is high for exactly one cycle per modulator cycle: the last cycle in which `ref_sel` is high.
- R11: If `run` is sampled low at the last position of a modulator cycle, all outputs stay low from then on. If `run` falls earlier, the cycle in progress still completes in full.
- R12: If `rst` is sampled high in the middle of a cycle, all outputs are low after that same edge, whatever the position was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Level request to keep producing modulator cycles |
| pre_amp | output | 1 | Phase one, primary: inverting amplifier precharge |
| pre_ref | output | 1 | Phase one, secondary: admit reference |
| int_cmp | output | 1 | Phase two, primary: integrator to comparator |
| int_in | output | 1 | Phase two, secondary: switch in sampled input |
| ref_sel | output | 1 | Phase three: select reference for next integration |
| cyc_start | output | 1 | Derived from first precharge line: first cycle of phase one |
| cyc_done | output | 1 | Last cycle of phase three |

## Verification
The checker assumes that `rst` is held for at least one edge before any check that depends on history. It also assumes that `run` is a plain level sampled on the rising edge, with no relation to where the cycle stands. It checks exclusion, order, dead time and width from the phase lines alone. The stimulus drives `run` and `rst` only on falling edges. It sweeps the point where `run` drops and the point where reset strikes across every position of a modulator cycle. A position-based model in the bench predicts every output on every cycle.

// File: rtl/nolap3_pkg.sv
package nolap3_pkg;

  typedef enum logic [2:0] {
    SL_IDLE = 3'd0,
    SL_PH1  = 3'd1,
    SL_GAP1 = 3'd2,
    SL_PH2  = 3'd3,
    SL_GAP2 = 3'd4,
    SL_PH3  = 3'd5,
    SL_GAP3 = 3'd6
  } slot_e;

  // bit positions inside the registered output bundle
  localparam int unsigned OB_PRE_AMP = 0;
  localparam int unsigned OB_PRE_REF = 1;
  localparam int unsigned OB_INT_CMP = 2;
  localparam int unsigned OB_INT_IN  = 3;
  localparam int unsigned OB_REF_SEL = 4;
  localparam int unsigned OB_START   = 5;
  localparam int unsigned OB_DONE    = 6;
  localparam int unsigned OB_COUNT   = 7;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nolap3_seq.sv
module nolap3_seq
  import nolap3_pkg::*;
#(
  parameter int unsigned PH1_W = 3,
  parameter int unsigned PH2_W = 5,
  parameter int unsigned PH3_W = 2,
  parameter int unsigned GAP_W = 1,
  parameter int unsigned CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output slot_e         slot,
  output logic [CW-1:0] off
);

  localparam logic [CW-1:0] L_PH1 = CW'(PH1_W - 1);
  localparam logic [CW-1:0] L_PH2 = CW'(PH2_W - 1);
  localparam logic [CW-1:0] L_PH3 = CW'(PH3_W - 1);
  localparam logic [CW-1:0] L_GAP = CW'(GAP_W - 1);

  logic [CW-1:0] last_off;
  slot_e         next_slot;

  always_comb begin
    last_off  = L_GAP;
    next_slot = SL_IDLE;
    unique case (slot)
      SL_PH1:  begin last_off = L_PH1; next_slot = SL_GAP1; end
      SL_GAP1: begin last_off = L_GAP; next_slot = SL_PH2;  end
      SL_PH2:  begin last_off = L_PH2; next_slot = SL_GAP2; end
      SL_GAP2: begin last_off = L_GAP; next_slot = SL_PH3;  end
      SL_PH3:  begin last_off = L_PH3; next_slot = SL_GAP3; end
      SL_GAP3: begin last_off = L_GAP; next_slot = run ? SL_PH1 : SL_IDLE; end
      default: begin last_off = '0;    next_slot = run ? SL_PH1 : SL_IDLE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= SL_IDLE;
      off  <= '0;
    end else if (slot == SL_IDLE) begin
      off <= '0;
      if (run) slot <= SL_PH1;
    end else if (off == last_off) begin
      off  <= '0;
      slot <= next_slot;
    end else begin
      off <= off + 1'b1;
    end
  end

endmodule

// File: rtl/nolap3_pair.sv
module nolap3_pair #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned INSET = 1,
  parameter int unsigned CW    = 3
) (
  input  logic          active,
  input  logic [CW-1:0] off,
  output logic          primary,
  output logic          secondary
);

  localparam logic [CW-1:0] LO = CW'(INSET);
  localparam logic [CW-1:0] HI = CW'(WIDTH - INSET - 1);

  assign primary = active;

  generate
    if (INSET == 0) begin : g_full
      assign secondary = active;
    end else begin : g_inset
      assign secondary = active && (off >= LO) && (off <= HI);
    end
  endgenerate

endmodule

// File: rtl/nolap3_outreg.sv
module nolap3_outreg #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/nolap_clkgen3.sv
module nolap_clkgen3
  import nolap3_pkg::*;
#(
  parameter int unsigned PH1_W = 3,
  parameter int unsigned PH2_W = 5,
  parameter int unsigned PH3_W = 2,
  parameter int unsigned GAP_W = 1,
  parameter int unsigned INSET = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic pre_amp,
  output logic pre_ref,
  output logic int_cmp,
  output logic int_in,
  output logic ref_sel,
  output logic cyc_start,
  output logic cyc_done
);

  localparam int unsigned MAXW = max3(max3(PH1_W, PH2_W, PH3_W), GAP_W, 1);
  localparam int unsigned CW   = (MAXW < 2) ? 1 : $clog2(MAXW);

  slot_e                slot;
  logic [CW-1:0]        off;
  logic [OB_COUNT-1:0]  bundle_d;
  logic [OB_COUNT-1:0]  bundle_q;
  logic                 p1_pri, p1_sec, p2_pri, p2_sec;

  nolap3_seq #(
    .PH1_W(PH1_W), .PH2_W(PH2_W), .PH3_W(PH3_W), .GAP_W(GAP_W), .CW(CW)
  ) u_seq (
    .clk (clk),
    .rst (rst),
    .run (run),
    .slot(slot),
    .off (off)
  );

  nolap3_pair #(.WIDTH(PH1_W), .INSET(INSET), .CW(CW)) u_pair1 (
    .active   (slot == SL_PH1),
    .off      (off),
    .primary  (p1_pri),
    .secondary(p1_sec)
  );

  nolap3_pair #(.WIDTH(PH2_W), .INSET(INSET), .CW(CW)) u_pair2 (
    .active   (slot == SL_PH2),
    .off      (off),
    .primary  (p2_pri),
    .secondary(p2_sec)
  );

  always_comb begin
    bundle_d             = '0;
    bundle_d[OB_PRE_AMP] = p1_pri;
    bundle_d[OB_PRE_REF] = p1_sec;
    bundle_d[OB_INT_CMP] = p2_pri;
    bundle_d[OB_INT_IN]  = p2_sec;
    bundle_d[OB_REF_SEL] = (slot == SL_PH3);
    bundle_d[OB_START]   = p1_pri && (off == '0);
    bundle_d[OB_DONE]    = (slot == SL_PH3) && (off == CW'(PH3_W - 1));
  end

  nolap3_outreg #(.N(OB_COUNT)) u_oreg (
    .clk(clk),
    .rst(rst),
    .d  (bundle_d),
    .q  (bundle_q)
  );

  assign pre_amp   = bundle_q[OB_PRE_AMP];
  assign pre_ref   = bundle_q[OB_PRE_REF];
  assign int_cmp   = bundle_q[OB_INT_CMP];
  assign int_in    = bundle_q[OB_INT_IN];
  assign ref_sel   = bundle_q[OB_REF_SEL];
  assign cyc_start = bundle_q[OB_START];
  assign cyc_done  = bundle_q[OB_DONE];

endmodule

// File: rtl/nolap_clkgen3_chk.sv
module nolap_clkgen3_chk #(
  parameter int unsigned PH1_W = 3,
  parameter int unsigned PH2_W = 5,
  parameter int unsigned PH3_W = 2,
  parameter int unsigned GAP_W = 1
) (
  input logic clk,
  input logic rst,
  input logic pre_amp,
  input logic pre_ref,
  input logic int_cmp,
  input logic int_in,
  input logic ref_sel,
  input logic cyc_start,
  input logic cyc_done
);

  logic [15:0] gap_cnt, len1, len2, len3;
  logic [1:0]  last_ph;
  logic        q1, q2, q3;
  logic        all_low;

  assign all_low = !pre_amp && !int_cmp && !ref_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
      len1 <= '0; len2 <= '0; len3 <= '0;
      last_ph <= 2'd0;
      q1 <= 1'b0; q2 <= 1'b0; q3 <= 1'b0;
    end else begin
      q1 <= pre_amp; q2 <= int_cmp; q3 <= ref_sel;
      len1 <= pre_amp ? len1 + 16'd1 : 16'd0;
      len2 <= int_cmp ? len2 + 16'd1 : 16'd0;
      len3 <= ref_sel ? len3 + 16'd1 : 16'd0;
      if (all_low) gap_cnt <= (gap_cnt == 16'hFFFF) ? gap_cnt : gap_cnt + 16'd1;
      else         gap_cnt <= '0;
      if (pre_amp)      last_ph <= 2'd1;
      else if (int_cmp) last_ph <= 2'd2;
      else if (ref_sel) last_ph <= 2'd3;
    end
  end

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pre_amp, int_cmp, ref_sel}));

  assert_order_ph2_R8: assert property (@(posedge clk) disable iff (rst)
    (int_cmp && !q2) |-> (last_ph == 2'd1 && gap_cnt == 16'(GAP_W)));

  assert_order_ph3_R8: assert property (@(posedge clk) disable iff (rst)
    (ref_sel && !q3) |-> (last_ph == 2'd2 && gap_cnt == 16'(GAP_W)));

  assert_order_ph1_R8: assert property (@(posedge clk) disable iff (rst)
    (pre_amp && !q1) |-> (last_ph == 2'd0 || (last_ph == 2'd3 && gap_cnt >= 16'(GAP_W))));

  assert_width_ph1_R3: assert property (@(posedge clk) disable iff (rst)
    (!pre_amp && q1) |-> (len1 == 16'(PH1_W)));

  assert_width_ph2_R5: assert property (@(posedge clk) disable iff (rst)
    (!int_cmp && q2) |-> (len2 == 16'(PH2_W)));

  assert_width_ph3_R7: assert property (@(posedge clk) disable iff (rst)
    (!ref_sel && q3) |-> (len3 == 16'(PH3_W)));

  assert_enclosed_ref_R4: assert property (@(posedge clk) disable iff (rst)
    pre_ref |-> pre_amp);

  assert_enclosed_in_R6: assert property (@(posedge clk) disable iff (rst)
    int_in |-> int_cmp);

  assert_start_on_rise_R9: assert property (@(posedge clk) disable iff (rst)
    cyc_start == (pre_amp && !q1));

  assert_done_last_R10: assert property (@(posedge clk) disable iff (rst)
    cyc_done |=> !ref_sel);

  assert_done_in_ph3_R10: assert property (@(posedge clk) disable iff (rst)
    cyc_done |-> ref_sel);

endmodule

bind nolap_clkgen3 nolap_clkgen3_chk #(
  .PH1_W(PH1_W), .PH2_W(PH2_W), .PH3_W(PH3_W), .GAP_W(GAP_W)
) u_chk (
  .clk(clk), .rst(rst),
  .pre_amp(pre_amp), .pre_ref(pre_ref), .int_cmp(int_cmp), .int_in(int_in),
  .ref_sel(ref_sel), .cyc_start(cyc_start), .cyc_done(cyc_done)
);

// File: tb/nolap_clkgen3_bench.sv
module nolap_clkgen3_bench;

  localparam int W1 = 3, W2 = 5, W3 = 2, G = 1, IN = 1;
  localparam int PER = W1 + W2 + W3 + 3 * G;
  localparam int P2 = W1 + G;
  localparam int P3 = W1 + W2 + 2 * G;

  logic clk = 1'b0, rst = 1'b1, run = 1'b0;
  logic pre_amp, pre_ref, int_cmp, int_in, ref_sel, cyc_start, cyc_done;

  int n_chk = 0, n_bad = 0;
  int m_act = 0, m_pos = 0;
  logic [6:0] expv = '0;

  always #10 clk = ~clk;

  nolap_clkgen3 #(.PH1_W(W1), .PH2_W(W2), .PH3_W(W3), .GAP_W(G), .INSET(IN)) u_nolap_clkgen3 (
    .clk(clk), .rst(rst), .run(run),
    .pre_amp(pre_amp), .pre_ref(pre_ref), .int_cmp(int_cmp), .int_in(int_in),
    .ref_sel(ref_sel), .cyc_start(cyc_start), .cyc_done(cyc_done)
  );

  // expected bundle {done,start,ref,in,cmp,ref1,amp} for position p
  function automatic logic [6:0] model(input int act, input int p);
    logic [6:0] v;
    v = '0;
    if (act != 0) begin
      v[0] = (p < W1);
      v[1] = (p >= IN) && (p < W1 - IN);
      v[2] = (p >= P2) && (p < P2 + W2);
      v[3] = (p >= P2 + IN) && (p < P2 + W2 - IN);
      v[4] = (p >= P3) && (p < P3 + W3);
      v[5] = (p == 0);
      v[6] = (p == P3 + W3 - 1);
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      expv = '0; m_act = 0; m_pos = 0;
    end else begin
      expv = model(m_act, m_pos);
      if (m_act == 0) begin
        if (run) begin m_act = 1; m_pos = 0; end
      end else if (m_pos == PER - 1) begin
        m_pos = 0; m_act = run ? 1 : 0;
      end else m_pos = m_pos + 1;
    end
  end

  task automatic chk(input string tag, input logic a, input logic e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, a, e, $time);
    end
  endtask

  // per-cycle comparison of every output against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 pre_amp", pre_amp, expv[0]);
      chk("R4 pre_ref", pre_ref, expv[1]);
      chk("R5 int_cmp", int_cmp, expv[2]);
      chk("R6 int_in", int_in, expv[3]);
      chk("R7 ref_sel", ref_sel, expv[4]);
      chk("R9 cyc_start", cyc_start, expv[5]);
      chk("R10 cyc_done", cyc_done, expv[6]);
      chk("R8 exclusive", ($countones({pre_amp, int_cmp, ref_sel}) <= 1), 1'b1);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic any_out();
    return pre_amp | pre_ref | int_cmp | int_in | ref_sel | cyc_start | cyc_done;
  endfunction

  initial begin
    cycles(3);
    chk("R1 reset low", any_out(), 1'b0);
    rst = 1'b0;
    cycles(5);
    chk("R1 idle low", any_out(), 1'b0);

    // R2: start latency
    run = 1'b1;
    cycles(1);
    chk("R2 not yet", pre_amp, 1'b0);
    cycles(1);
    chk("R2 first phase", pre_amp, 1'b1);
    chk("R9 start with phase", cyc_start, 1'b1);
    cycles(4 * PER);

    // R11: drop run at every position of the cycle
    for (int k = 0; k < PER; k++) begin
      run = 1'b0;
      cycles(PER + 4);
      chk("R11 idle after drop", any_out(), 1'b0);
      run = 1'b1;
      cycles(2 + k);
      run = 1'b0;
      cycles(2 * PER + 3);
      chk("R11 stopped", any_out(), 1'b0);
    end

    // R12: reset at every position while running
    for (int k = 0; k < PER; k++) begin
      run = 1'b1;
      cycles(2 + k + PER);
      rst = 1'b1;
      cycles(1);
      chk("R12 reset mid cycle", any_out(), 1'b0);
      run = 1'b0;
      rst = 1'b0;
      cycles(3);
      chk("R1 low after reset", any_out(), 1'b0);
    end

    // R10: exactly one done per cycle over a long run
    begin
      int dn = 0;
      int st = 0;
      run = 1'b1;
      cycles(2);
      for (int c = 0; c < 6 * PER; c++) begin
        if (cyc_done) dn++;
        if (cyc_start) st++;
        cycles(1);
      end
      chk("R10 one done per cycle", (dn == 6), 1'b1);
      chk("R9 one start per cycle", (st == 6), 1'b1);
      run = 1'b0;
      cycles(2 * PER);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule